// File: doc/BRIEF.md
# Integer ALU with Six-Flag Status Word

This block is a 32-bit combinational arithmetic and logic unit. It takes two operands and a three-bit operation code. It produces a result word and a six-bit status word. The unit supports addition, subtraction, bitwise AND, bitwise OR and bitwise XOR.

The status word holds the usual sign, zero, overflow and carry indications. It also holds two extra bits: a half carry taken at the nibble boundary, and an even-parity indication over the low byte of the result.

The status word can also be captured in a small register. This copy loads on a clock edge when the write enable is high. Later logic can then read the flags of an earlier operation while the datapath moves on to other work.

Top module: `alu_flag_unit`

## Requirements
- R1: `result` is `opa + opb` for op code 3'b000, `opa - opb` for 3'b001, `opa & opb` for 3'b010, `opa | opb` for 3'b011 and `opa ^ opb` for 3'b100. The codes 3'b101 to 3'b111 give a result of zero. All arithmetic is modulo 2^32.
- R2: `flags[5]` (negative) equals bit 31 of `result`.
- R3: `flags[4]` (zero) is 1 exactly when `result` is all zeros.
- R4: For add and subtract, `flags[3]` (overflow) is 1 when the signed two's-complement result does not fit in 32 bits.
- R5: For add, `flags[2]` (carry) is the carry out of bit 31. For subtract, it is the borrow: 1 when `opa < opb` as unsigned numbers.
- R6: For add, `flags[1]` (half carry) is the carry out of bit 3 into bit 4. For subtract, it is the borrow at that boundary: 1 when `opa[3:0] < opb[3:0]`.
- R7: `flags[0]` (parity) is 1 when `result[7:0]` holds an even number of ones.
- R8: For the logic codes and the unused codes, `flags[3:1]` are all zero. N, Z and P still follow the result.
- R9: On a rising `clk` edge with `rst_n` high and `flag_we` high, `flags_q` takes the value of `flags`.
- R10: On a rising `clk` edge with `rst_n` high and `flag_we` low, `flags_q` keeps its value.
- R11: On a rising `clk` edge with `rst_n` low, `flags_q` becomes 6'b000000, whatever the value of `flag_we`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the captured status register |
| rst_n | input | 1 | Synchronous active-low reset of `flags_q` |
| op_sel | input | 3 | Operation code |
| opa | input | 32 | First operand |
| opb | input | 32 | Second operand |
| flag_we | input | 1 | Capture enable for `flags_q` |
| result | output | 32 | Combinational result |
| flags | output | 6 | Combinational status {N,Z,V,C,A,P} |
| flags_q | output | 6 | Registered copy of the status word |

## Verification
The datapath has no internal state, so a wrong carry split or a wrong operand inversion shows on `result` or `flags` in the same cycle that the operands are applied. The vector table picks operands that sit on the nibble boundary and on the sign boundary, so a fault in half carry, borrow or overflow changes a specific flag bit right away. The only stored state is the captured status register. A fault in its load or hold logic shows on `flags_q` one edge after the enable is applied or removed.

// File: rtl/alu_pkg.sv
// alu_pkg: shared operation codes and status bit positions for the ALU.
// Assumes the 3-bit op code layout described in the brief.
package alu_pkg;
    typedef enum logic [2:0] {
        OP_ADD = 3'b000,
        OP_SUB = 3'b001,
        OP_AND = 3'b010,
        OP_OR  = 3'b011,
        OP_XOR = 3'b100
    } alu_op_e;

    localparam int FLAG_W  = 6;
    localparam int FL_NEG  = 5;
    localparam int FL_ZERO = 4;
    localparam int FL_OVF  = 3;
    localparam int FL_CRY  = 2;
    localparam int FL_HALF = 1;
    localparam int FL_PAR  = 0;
endpackage

// File: rtl/alu_addsub.sv
// alu_addsub: adder/subtractor split at the half-carry boundary.
// Works out a + b, or a + ~b + 1 when sub is high.
// Carry and half carry come out as borrows in subtract mode.
// Assumes 0 < AUX_POS < W.
module alu_addsub #(
    parameter int W       = 32,
    parameter int AUX_POS = 4
) (
    input  logic         sub,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] sum,
    output logic         carry,
    output logic         half,
    output logic         ovf
);
    localparam int HI_W = W - AUX_POS;

    logic [W-1:0]      b_eff;
    logic [AUX_POS:0]  lo;
    logic [HI_W:0]     hi;

    // Invert the second operand and inject a carry for subtract, then add in two pieces.
    always_comb begin
        b_eff = sub ? ~b : b;
        lo    = {1'b0, a[AUX_POS-1:0]} + {1'b0, b_eff[AUX_POS-1:0]}
              + {{AUX_POS{1'b0}}, sub};
        hi    = {1'b0, a[W-1:AUX_POS]} + {1'b0, b_eff[W-1:AUX_POS]}
              + {{HI_W{1'b0}}, lo[AUX_POS]};
        sum   = {hi[HI_W-1:0], lo[AUX_POS-1:0]};
        carry = hi[HI_W] ^ sub;
        half  = lo[AUX_POS] ^ sub;
        ovf   = (a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1]);
    end
endmodule

// File: rtl/alu_logic.sv
// alu_logic: bitwise unit for AND, OR and XOR.
// Any code it does not handle gives zero.
module alu_logic #(
    parameter int W = 32
) (
    input  logic [2:0]   op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y
);
    import alu_pkg::*;

    // Select the bitwise function for this code.
    always_comb begin
        case (op)
            OP_AND:  y = a & b;
            OP_OR:   y = a | b;
            OP_XOR:  y = a ^ b;
            default: y = '0;
        endcase
    end
endmodule

// File: rtl/alu_flaggen.sv
// alu_flaggen: builds the six-bit status word from the result and the adder flags.
// Assumes PAR_BITS <= W. The adder flags are used only when is_arith is high.
module alu_flaggen #(
    parameter int W        = 32,
    parameter int PAR_BITS = 8
) (
    input  logic                      is_arith,
    input  logic [W-1:0]              res,
    input  logic                      ar_ovf,
    input  logic                      ar_carry,
    input  logic                      ar_half,
    output logic [alu_pkg::FLAG_W-1:0] fl
);
    import alu_pkg::*;

    // Put each status bit at its fixed position.
    always_comb begin
        fl          = '0;
        fl[FL_NEG]  = res[W-1];
        fl[FL_ZERO] = (res == '0);
        fl[FL_OVF]  = is_arith & ar_ovf;
        fl[FL_CRY]  = is_arith & ar_carry;
        fl[FL_HALF] = is_arith & ar_half;
        fl[FL_PAR]  = ~^res[PAR_BITS-1:0];
    end
endmodule

// File: rtl/alu_flag_unit.sv
// alu_flag_unit: top of the ALU. The datapath is combinational.
// The status word also has a captured copy with a synchronous active-low reset.
// Assumes op_sel and the operands are stable around the clock edge when flag_we is high.
module alu_flag_unit #(
    parameter int W        = 32,
    parameter int AUX_POS  = 4,
    parameter int PAR_BITS = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [2:0]                  op_sel,
    input  logic [W-1:0]                opa,
    input  logic [W-1:0]                opb,
    input  logic                        flag_we,
    output logic [W-1:0]                result,
    output logic [alu_pkg::FLAG_W-1:0]  flags,
    output logic [alu_pkg::FLAG_W-1:0]  flags_q
);
    import alu_pkg::*;

    logic         is_arith;
    logic [W-1:0] as_sum, lg_y;
    logic         as_carry, as_half, as_ovf;

    // Decide whether the adder path drives the result.
    always_comb is_arith = (op_sel == OP_ADD) || (op_sel == OP_SUB);

    alu_addsub #(.W(W), .AUX_POS(AUX_POS)) u_addsub (
        .sub   (op_sel == OP_SUB),
        .a     (opa),
        .b     (opb),
        .sum   (as_sum),
        .carry (as_carry),
        .half  (as_half),
        .ovf   (as_ovf)
    );

    alu_logic #(.W(W)) u_logic (
        .op (op_sel),
        .a  (opa),
        .b  (opb),
        .y  (lg_y)
    );

    // Pick the adder sum or the bitwise output.
    always_comb result = is_arith ? as_sum : lg_y;

    alu_flaggen #(.W(W), .PAR_BITS(PAR_BITS)) u_flags (
        .is_arith (is_arith),
        .res      (result),
        .ar_ovf   (as_ovf),
        .ar_carry (as_carry),
        .ar_half  (as_half),
        .fl       (flags)
    );

    // Captured status: cleared by reset, loaded when enabled, held otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)       flags_q <= '0;
        else if (flag_we) flags_q <= flags;
    end
endmodule

// File: rtl/alu_flag_checker.sv
// alu_flag_checker: properties over the ports of alu_flag_unit, attached with bind.
module alu_flag_checker (
    input logic        clk,
    input logic        rst_n,
    input logic [2:0]  op_sel,
    input logic [31:0] result,
    input logic [5:0]  flags,
    input logic        flag_we,
    input logic [5:0]  flags_q
);
    // Negative flag follows the sign bit of the result (R2).
    assert_neg_sign_R2: assert property (@(posedge clk) disable iff (!rst_n)
        flags[5] == result[31]);

    // Parity flag means even parity of the low byte (R7).
    assert_even_parity_R7: assert property (@(posedge clk) disable iff (!rst_n)
        flags[0] == ~^result[7:0]);

    // Codes other than add and subtract leave V, C and A clear (R8).
    assert_logic_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel > 3'b001) |-> (flags[3:1] == 3'b000));

    // Capture with the enable high (R9).
    assert_store_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flag_we |=> (flags_q == $past(flags)));

    // Hold with the enable low (R10).
    assert_store_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_we |=> $stable(flags_q));
endmodule

bind alu_flag_unit alu_flag_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .op_sel  (op_sel),
    .result  (result),
    .flags   (flags),
    .flag_we (flag_we),
    .flags_q (flags_q)
);

// File: tb/sim_alu_flag_unit.sv
// sim_alu_flag_unit: walks a vector table, then runs directed tests of the captured status register.
module sim_alu_flag_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  op_sel = '0;
    logic [31:0] opa = '0, opb = '0;
    logic        flag_we = 1'b0;
    logic [31:0] result;
    logic [5:0]  flags, flags_q;
    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    alu_flag_unit u0 (
        .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .opa(opa), .opb(opb),
        .flag_we(flag_we), .result(result), .flags(flags), .flags_q(flags_q)
    );

    // {op, a, b, expected result, expected flags {N,Z,V,C,A,P}}
    localparam int NV = 15;
    localparam logic [104:0] VEC [NV] = '{
        {3'd0, 32'h00000001, 32'h00000001, 32'h00000002, 6'h00},
        {3'd0, 32'h7FFFFFFF, 32'h00000001, 32'h80000000, 6'h2B},
        {3'd0, 32'hFFFFFFFF, 32'h00000001, 32'h00000000, 6'h17},
        {3'd0, 32'h0000000F, 32'h00000001, 32'h00000010, 6'h02},
        {3'd0, 32'h80000000, 32'h80000000, 32'h00000000, 6'h1D},
        {3'd1, 32'h00000005, 32'h00000003, 32'h00000002, 6'h00},
        {3'd1, 32'h00000003, 32'h00000005, 32'hFFFFFFFE, 6'h26},
        {3'd1, 32'h80000000, 32'h00000001, 32'h7FFFFFFF, 6'h0B},
        {3'd1, 32'h00000007, 32'h00000007, 32'h00000000, 6'h11},
        {3'd2, 32'hF0F0F0F0, 32'hFF00FF00, 32'hF000F000, 6'h21},
        {3'd3, 32'h00000000, 32'h00000000, 32'h00000000, 6'h11},
        {3'd3, 32'h12345678, 32'h0000000F, 32'h1234567F, 6'h00},
        {3'd4, 32'hFFFFFFFF, 32'h0000FFFF, 32'hFFFF0000, 6'h21},
        {3'd4, 32'hAAAAAAAA, 32'hAAAAAAAA, 32'h00000000, 6'h11},
        {3'd5, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h00000000, 6'h11}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    initial begin
        #200000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R11: reset clears the captured copy even with the enable high.
        flag_we = 1'b1;
        op_sel = 3'd0; opa = 32'hFFFFFFFF; opb = 32'h1;
        repeat (3) @(negedge clk);
        check("R11 reset clears flags_q", {26'd0, flags_q}, 32'h0);
        flag_we = 1'b0;
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            op_sel = VEC[i][104:102];
            opa    = VEC[i][101:70];
            opb    = VEC[i][69:38];
            #1;
            check("R1 result", result, VEC[i][37:6]);
            check("R2 neg",    {31'd0, flags[5]}, {31'd0, VEC[i][5]});
            check("R3 zero",   {31'd0, flags[4]}, {31'd0, VEC[i][4]});
            check("R4 ovf",    {31'd0, flags[3]}, {31'd0, VEC[i][3]});
            check("R5 carry",  {31'd0, flags[2]}, {31'd0, VEC[i][2]});
            check("R6 half",   {31'd0, flags[1]}, {31'd0, VEC[i][1]});
            check("R7 parity", {31'd0, flags[0]}, {31'd0, VEC[i][0]});
            if (VEC[i][104:102] > 3'd1)
                check("R8 logic clears VCA", {29'd0, flags[3:1]}, 32'h0);
        end

        // R9: load 0x2B with the enable high.
        @(negedge clk);
        op_sel = 3'd0; opa = 32'h7FFFFFFF; opb = 32'h1; flag_we = 1'b1;
        @(negedge clk);
        check("R9 load flags_q", {26'd0, flags_q}, 32'h2B);

        // R10: enable low, inputs that would give 0x17, value held.
        op_sel = 3'd0; opa = 32'hFFFFFFFF; opb = 32'h1; flag_we = 1'b0;
        repeat (2) @(negedge clk);
        check("R10 hold flags_q", {26'd0, flags_q}, 32'h2B);

        // R9: load again, then R11 reset with the enable high.
        flag_we = 1'b1;
        @(negedge clk);
        check("R9 reload flags_q", {26'd0, flags_q}, 32'h17);
        rst_n = 1'b0;
        @(negedge clk);
        check("R11 reset over enable", {26'd0, flags_q}, 32'h0);
        rst_n = 1'b1; flag_we = 1'b0;
        @(negedge clk);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule